// File: doc/BRIEF.md
# Interval Tick Timer with Wrap Counter

The block is a periodic timer on a small register port. A 4-bit prescaler divides the system clock by sixteen. Each prescaler terminal count advances a 20-bit tick counter, which climbs from zero to a programmed limit and then returns to zero. Every return to zero is a wrap. A wrap sets a pending flag and adds one to a 12-bit wrap counter.

Software reads the wrap count and the current tick value as one 32-bit snapshot word. Two views of that word exist. The acknowledge view clears the pending flag and the wrap count as a side effect of the read. The peek view leaves both untouched. A driver adds the acknowledged wrap counts, scaled by the period, to an accumulated total. With the peek view it can then form a monotonic time base between interrupts.

The level interrupt output is the pending flag masked by an interrupt enable. Clearing the run enable does not stop the timer at once. The tick counter finishes the current period, comes back to zero, and only then halts. Software confirms the halt by polling for a zero tick value.

Top module: `interval_tick_timer`

## Requirements
- R1: After a synchronous reset, every register reads zero: mode, pending flag, wrap count, tick and prescaler. `irq` and `bus_rdata` are 0.
- R2: While the timer runs, the tick value changes only once in every 16 clock cycles, on the prescaler's terminal count.
- R3: With limit P in mode bits 19:0, the tick value steps 0, 1, … P and then back to 0, giving P+1 ticks per period. A step taken when the tick is already at or above P goes to 0 and counts as a wrap. P = 0 wraps on every step.
- R4: Each wrap sets the pending flag (word 1, bit 0) and adds one to the 12-bit wrap count, modulo 4096.
- R5: A read of word 2 (byte offset 0x08) returns the wrap count in bits 31:20 and the tick in bits 19:0. The read also clears the flag and the wrap count. If a wrap falls in the same cycle, the flag ends up set and the count ends up at 1.
- R6: A read of word 3 (byte offset 0x0C) returns the same layout as word 2. It changes neither the flag nor the wrap count.
- R7: When the run enable (mode bit 24) is cleared while the tick is non-zero, counting continues until the tick wraps to 0. That wrap is counted. The tick then stays at 0. When the enable is cleared with the tick at 0, the tick stays at 0.
- R8: `irq` is high exactly when the flag is set and the interrupt enable (mode bit 25) is set. Clearing bit 25 alone lowers `irq`, but counting and flag setting go on.
- R9: Word 0 reads back limit in bits 19:0, run enable in bit 24 and interrupt enable in bit 25, with all other bits zero. Writing word 0 restarts neither the tick counter nor the prescaler.
- R10: `bus_rdata` is loaded at the clock edge where `bus_rd` is sampled high, with the state from before that edge, and holds otherwise. Writes to words 1, 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_word | input | 2 | Word index: 0 mode, 1 status, 2 acknowledge snapshot, 3 peek snapshot |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read side effects apply only with it |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, flag AND interrupt enable |

## Verification
The checker watches a set of properties on every cycle:
- the tick moves only on a prescaler terminal count;
- a wrap-count increment always follows a wrap;
- the acknowledge read clears the flag and the count, while the peek read keeps them;
- a halted, disabled counter stays at zero;
- a write that drops the interrupt enable lowers `irq`;
- read data holds between strobes.

Only the bench scenarios can show the following:
- the exact period length for a given limit;
- the drain sequence, ending in a counted wrap before the halt;
- rollover of the wrap count past 4095;
- a wrap and an acknowledge in the same cycle;
- readback values under random mixes of reads and writes.

// File: rtl/itt_pkg.sv
package itt_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned LIMIT_W  = 20;
    localparam int unsigned WRAP_W   = 12;
    localparam int unsigned PRESC_W  = 4;
    localparam int unsigned RUN_BIT  = 24;
    localparam int unsigned IEN_BIT  = 25;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_ACK  = 2'd2,
        SEL_PEEK = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic               irq_en;
        logic               run_en;
        logic [LIMIT_W-1:0] limit;
    } mode_t;

    function automatic mode_t unpack_mode(input logic [DATA_W-1:0] word);
        mode_t m;
        m.limit  = word[LIMIT_W-1:0];
        m.run_en = word[RUN_BIT];
        m.irq_en = word[IEN_BIT];
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] pack_mode(input mode_t m);
        logic [DATA_W-1:0] w;
        w = '0;
        w[LIMIT_W-1:0] = m.limit;
        w[RUN_BIT]     = m.run_en;
        w[IEN_BIT]     = m.irq_en;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_snapshot(input logic [WRAP_W-1:0]  wraps,
                                                        input logic [LIMIT_W-1:0] tick);
        logic [DATA_W-1:0] w;
        w = '0;
        w[LIMIT_W-1:0]               = tick;
        w[LIMIT_W+WRAP_W-1:LIMIT_W]  = wraps;
        return w;
    endfunction

endpackage

// File: rtl/itt_prescaler.sv
module itt_prescaler #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    output logic         term,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (run) begin
            count <= count + W'(1);
        end
    end

    assign term = run && (&count);

endmodule

// File: rtl/itt_tick_counter.sv
module itt_tick_counter #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] tick,
    output logic         wrap
);

    assign wrap = step && (tick >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick <= '0;
        end else if (step) begin
            tick <= wrap ? '0 : tick + W'(1);
        end
    end

endmodule

// File: rtl/itt_wrap_tracker.sv
module itt_wrap_tracker #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wrap,
    input  logic         ack,
    output logic         flag,
    output logic [W-1:0] wraps
);

    logic [W-1:0] base;

    assign base = ack ? '0 : wraps;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            wraps <= '0;
        end else begin
            flag  <= wrap | (flag & ~ack);
            wraps <= base + W'(wrap);
        end
    end

endmodule

// File: rtl/interval_tick_timer.sv
module interval_tick_timer
    import itt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_word,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    reg_sel_e           sel;
    mode_t              mode_q;
    logic               run;
    logic               presc_tc;
    logic [PRESC_W-1:0] presc;
    logic [LIMIT_W-1:0] tick;
    logic               tick_wrap;
    logic               flag;
    logic [WRAP_W-1:0]  wraps;
    logic               ack_rd;
    logic [DATA_W-1:0]  rd_mux;

    assign sel    = reg_sel_e'(bus_word);
    assign ack_rd = bus_rd && (sel == SEL_ACK);
    assign run    = mode_q.run_en || (tick != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (bus_wr && sel == SEL_MODE) begin
            mode_q <= unpack_mode(bus_wdata);
        end
    end

    itt_prescaler #(.W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .term  (presc_tc),
        .count (presc)
    );

    itt_tick_counter #(.W(LIMIT_W)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .step  (presc_tc),
        .limit (mode_q.limit),
        .tick  (tick),
        .wrap  (tick_wrap)
    );

    itt_wrap_tracker #(.W(WRAP_W)) u_wrap (
        .clk   (clk),
        .rst   (rst),
        .wrap  (tick_wrap),
        .ack   (ack_rd),
        .flag  (flag),
        .wraps (wraps)
    );

    always_comb begin
        unique case (sel)
            SEL_MODE: rd_mux = pack_mode(mode_q);
            SEL_STAT: rd_mux = {{(DATA_W-1){1'b0}}, flag};
            default:  rd_mux = pack_snapshot(wraps, tick);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assign irq = flag & mode_q.irq_en;

endmodule

// File: rtl/itt_checker.sv
module itt_checker
    import itt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        bus_word,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              presc_tc,
    input logic [LIMIT_W-1:0] tick,
    input logic              tick_wrap,
    input logic              flag,
    input logic [WRAP_W-1:0] wraps,
    input logic              run_en
);

    AST_TICK_ON_PRESC: assert property (@(posedge clk) disable iff (rst)
        !$stable(tick) |-> $past(presc_tc)); // R2

    AST_COUNT_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (wraps != $past(wraps) && wraps != '0) |-> $past(tick_wrap)); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_word == 2'd2 && !tick_wrap) |=> (wraps == '0 && !flag)); // R5

    AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_word == 2'd3 && !tick_wrap) |=> ($stable(wraps) && $stable(flag))); // R6

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run_en && tick == '0) |=> (tick == '0)); // R7

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word == 2'd0 && !bus_wdata[IEN_BIT]) |=> !irq); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)); // R10

endmodule

bind interval_tick_timer itt_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_word  (bus_word),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .presc_tc  (presc_tc),
    .tick      (tick),
    .tick_wrap (tick_wrap),
    .flag      (flag),
    .wraps     (wraps),
    .run_en    (mode_q.run_en)
);

// File: tb/interval_tick_timer_test.sv
`timescale 1ns/1ps
module interval_tick_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_word = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    interval_tick_timer uut (
        .clk(clk), .rst(rst), .bus_word(bus_word), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Reference model built from the requirements
    logic [19:0] m_limit, m_tick;
    logic        m_run_en, m_irq_en, m_flag;
    logic [3:0]  m_presc;
    logic [11:0] m_wraps;
    logic [31:0] m_rdata;

    function automatic logic [31:0] snap(input logic [11:0] w, input logic [19:0] t);
        return {w, t};
    endfunction

    always @(posedge clk) begin
        logic run, step, wrap, ack;
        logic [31:0] rv;
        if (rst) begin
            m_limit = '0; m_tick = '0; m_run_en = 0; m_irq_en = 0; m_flag = 0;
            m_presc = '0; m_wraps = '0; m_rdata = '0;
        end else begin
            case (bus_word)
                2'd0: rv = {6'd0, m_irq_en, m_run_en, 4'd0, m_limit};
                2'd1: rv = {31'd0, m_flag};
                default: rv = snap(m_wraps, m_tick);
            endcase
            run  = m_run_en || (m_tick != 0);
            step = run && (m_presc == 4'hF);
            wrap = step && (m_tick >= m_limit);
            ack  = bus_rd && (bus_word == 2'd2);
            if (bus_rd) m_rdata = rv;
            if (run) m_presc = m_presc + 4'd1;
            if (step) m_tick = wrap ? 20'd0 : m_tick + 20'd1;
            m_wraps = (ack ? 12'd0 : m_wraps) + {11'd0, wrap};
            m_flag  = wrap | (m_flag & ~ack);
            if (bus_wr && bus_word == 2'd0) begin
                m_limit  = bus_wdata[19:0];
                m_run_en = bus_wdata[24];
                m_irq_en = bus_wdata[25];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R8: interrupt level checked on every cycle
    always @(negedge clk) begin
        if (!rst && !done) chk("R8", {31'd0, irq}, {31'd0, m_flag & m_irq_en});
    end

    logic [31:0] last;

    task automatic rd(input logic [1:0] w, input string req);
        bus_rd = 1'b1; bus_word = w;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, bus_rdata, m_rdata);
        last = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    function automatic logic [31:0] mode_word(input bit ien, input bit en, input logic [19:0] lim);
        return {6'd0, ien, en, 4'd0, lim};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] first;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", bus_rdata, 32'd0);
        chk("R1", {31'd0, irq}, 32'd0);
        rd(2'd3, "R1"); chk("R1", last, 32'd0);
        rd(2'd0, "R1"); chk("R1", last, 32'd0);

        // R9 readback of the mode word
        wr(2'd0, mode_word(1, 1, 20'd9));
        rd(2'd0, "R9"); chk("R9", last, 32'h0300_0009);

        // R2 R3 R4: two periods of ten ticks and some more
        repeat (16 * 10 * 2 + 7) @(negedge clk);
        rd(2'd3, "R3");
        rd(2'd1, "R4"); chk("R4", last, 32'd1);
        chk("R8", {31'd0, irq}, 32'd1);

        // R6 peek leaves the state alone
        rd(2'd3, "R6"); first = last;
        rd(2'd3, "R6"); chk("R6", last[31:20], first[31:20]);
        rd(2'd1, "R6");

        // R5 acknowledge read
        rd(2'd2, "R5");
        rd(2'd1, "R5");
        rd(2'd3, "R5");

        // R8 mask the interrupt with the timer still running
        wr(2'd0, mode_word(0, 1, 20'd9));
        repeat (400) @(negedge clk);
        chk("R8", {31'd0, irq}, 32'd0);
        rd(2'd1, "R8"); chk("R8", last, 32'd1);

        // R9 mode write does not restart the counters
        rd(2'd3, "R9");
        wr(2'd0, mode_word(1, 1, 20'd9));
        rd(2'd3, "R9");

        // R10 writes to other words are ignored
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd0, "R10"); chk("R10", last, 32'h0300_0009);
        rd(2'd3, "R10");

        // R7 drain on disable
        repeat (37) @(negedge clk);
        wr(2'd0, mode_word(1, 0, 20'd9));
        rd(2'd3, "R7");
        for (int i = 0; i < 400 && last[19:0] != 0; i++) rd(2'd3, "R7");
        repeat (100) @(negedge clk);
        rd(2'd3, "R7"); chk("R7", {12'd0, last[19:0]}, 32'd0);
        rd(2'd1, "R7");

        // R3 limit of zero wraps on every step
        rd(2'd2, "R3");
        wr(2'd0, mode_word(1, 1, 20'd0));
        repeat (16 * 6) @(negedge clk);
        rd(2'd3, "R3");

        // R4 wrap count rolls over past 4095
        rd(2'd2, "R4");
        repeat (16 * 4100) @(negedge clk);
        rd(2'd3, "R4");

        // R5 acknowledge colliding with wraps, random mix
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom_range(0, 99);
            if (op < 8) begin
                wr(2'd0, mode_word($urandom_range(0, 1), $urandom_range(0, 3) != 0,
                                   20'($urandom_range(0, 5))));
            end else if (op < 12) begin
                wr(2'($urandom_range(1, 3)), $urandom);
            end else if (op < 50) begin
                rd(2'($urandom_range(0, 3)), "R5");
            end else begin
                @(negedge clk);
            end
        end

        finish_run();
    end

endmodule